// File: doc/BRIEF.md
# DDR SDRAM Command Decoder with Bank Tracking

This block watches the command pins of a double-data-rate synchronous DRAM interface and samples them on every rising clock edge. It turns each sampled pin pattern into one of a small set of commands: open a row, column read, column write, close a row, and auto-refresh. It also follows the effect of each command. Four bank-state flags record which banks hold an open row. One burst tracker counts down the beats still to move and reports a read-data window that starts a programmable number of clocks after the read.

A single command pin changes meaning with the command. On a column read or write, the A10 line asks for the bank to close by itself once the burst ends. On a close command, the same line widens the close to every bank. A close command also cuts off any burst in flight. A refresh is accepted only when no bank holds an open row, and it leaves all banks closed.

A command that breaks the bank protocol raises a one-cycle error flag and is otherwise dropped. A controller model or a protocol monitor can use the strobes, the bank flags and the error flag to follow what the memory is doing.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: Every command is decoded from the pins sampled at a rising clock edge. Its strobe (`act_stb`, `rd_stb`, `wr_stb`, `pre_stb`, `ref_stb`) or `cmd_err` is high for exactly the one cycle after that edge, and at most one of the six is high at a time. With `cs_n` high nothing is decoded.
- R2: Open-row is `ras_n`=0, `cas_n`=1, `we_n`=1. If the bank chosen by `ba` is closed, that bank's bit in `bank_open` is set after the edge.
- R3: Read is `ras_n`=1, `cas_n`=0, `we_n`=1, and write is `ras_n`=1, `cas_n`=0, `we_n`=0. Sent to an open bank, either one starts a burst. `burst_beats` shows the full length after the edge and then drops by 2 at every later edge. `burst_busy` is high while the count is non-zero, and `burst_wr` is 1 for a write.
- R4: `bl_sel` sets the burst length: 0 gives 2 beats, 1 gives 4, and 2 or 3 give 8. A burst therefore lasts length/2 clocks.
- R5: With `cl_sel`=0 the latency is 2 clocks, and with 1 it is 3. For a read accepted at edge N, `rd_valid` is high after edges N+latency up to N+latency+length/2-1. A write never raises it.
- R6: If A10 is 1 on an accepted read or write, the bank closes at the edge where the burst count reaches 0. A command at that same edge already sees the bank closed.
- R7: Close is `ras_n`=0, `cas_n`=1, `we_n`=0. With A10=0 it closes the bank chosen by `ba`. With A10=1 it closes all banks. It is accepted whatever the bank state.
- R8: Any accepted close ends the burst in flight, so after that edge `burst_beats` is 0.
- R9: Refresh is `ras_n`=0, `cas_n`=0, `we_n`=1 with `cke`=1. It is accepted only when every bank is closed, and it leaves every bank closed.
- R10: These commands raise `cmd_err` and change no bank flag and no burst state: open-row to an open bank, read or write to a closed bank, and refresh while any bank is open.
- R11: A read or write that arrives while the burst count is above 2 is an error. One that arrives when the count is 2 is accepted and restarts the count gaplessly.
- R12: No-op (`ras_n`, `cas_n`, `we_n` all 1), all three low, burst stop (`ras_n`=1, `cas_n`=1, `we_n`=0), and the refresh pattern with `cke`=0 are all ignored: no strobe, no error, no bank change.
- R13: A synchronous active-high `rst` closes all banks, clears the burst and read window, and deasserts every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples the pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low selects the device |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable |
| cke | input | 1 | Clock enable, qualifies refresh |
| a10 | input | 1 | Auto-close on read/write, all-bank close on close |
| ba | input | BA_W | Bank address |
| bl_sel | input | 2 | Burst length code |
| cl_sel | input | 1 | CAS latency select, 0 = 2 clocks, 1 = 3 clocks |
| act_stb | output | 1 | Open-row accepted |
| rd_stb | output | 1 | Read accepted |
| wr_stb | output | 1 | Write accepted |
| pre_stb | output | 1 | Close accepted |
| ref_stb | output | 1 | Refresh accepted |
| cmd_err | output | 1 | Illegal command dropped |
| bank_open | output | NUM_BANKS | One bit per bank, 1 = row open |
| burst_busy | output | 1 | Burst in flight |
| burst_wr | output | 1 | Burst in flight is a write |
| burst_beats | output | CNT_W | Beats still to move |
| rd_valid | output | 1 | Read data window |

## Verification
A stale bank flag shows at the ports within one clock. The next command to that bank either sets `cmd_err` when it should not or fails to set it, and `bank_open` is compared after every command. A wrong burst count or a lost auto-close shows as a mismatch of `burst_beats`, `burst_busy` or `bank_open` in the very cycle the count should move. A misplaced read window is off by whole clocks in `rd_valid`, and the sweeps compare it every cycle for both latencies and every length. The same-edge cases (auto-close at the last beat, gapless restart) are driven directly, because a wrong priority there shows only at that one edge.

// File: rtl/ddrct_pkg.sv
package ddrct_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ACT,
        OP_RD,
        OP_WR,
        OP_PRE,
        OP_REF
    } op_e;

    typedef struct packed {
        logic wr;
        logic ap;
    } burst_attr_t;

    // Pin pattern to command; unsupported patterns fall to OP_NONE
    function automatic op_e decode_op(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n,
                                      input logic cke);
        op_e r;
        r = OP_NONE;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  r = OP_ACT;
                3'b101:  r = OP_RD;
                3'b100:  r = OP_WR;
                3'b010:  r = OP_PRE;
                3'b001:  r = cke ? OP_REF : OP_NONE;
                default: r = OP_NONE;
            endcase
        end
        return r;
    endfunction

    // Burst length code to beat count: 0->2, 1->4, 2/3->8
    function automatic int beats_of(input logic [1:0] code);
        int sh;
        sh = (code > 2'd2) ? 2 : int'(code);
        return 2 << sh;
    endfunction

endpackage

// File: rtl/ddrct_decode.sv
module ddrct_decode
    import ddrct_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    output op_e  op
);
    always_comb begin
        op = decode_op(cs_n, ras_n, cas_n, we_n, cke);
    end
endmodule

// File: rtl/ddrct_banks.sv
module ddrct_banks #(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] ret_mask,
    input  logic                 go_act,
    input  logic                 go_pre,
    input  logic                 pre_all,
    input  logic                 go_ref,
    input  logic [BA_W-1:0]      idx,
    output logic [NUM_BANKS-1:0] open_q
);
    logic [NUM_BANKS-1:0] open_d;

    always_comb begin
        open_d = open_q & ~ret_mask;
        if (go_act) open_d[idx] = 1'b1;
        if (go_pre) begin
            if (pre_all) open_d = '0;
            else         open_d[idx] = 1'b0;
        end
        if (go_ref) open_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) open_q <= '0;
        else     open_q <= open_d;
    end

    AST_ACT_SETS_BANK: assert property (@(posedge clk) disable iff (rst)
        go_act |=> open_q[$past(idx)]);                          // R2
    AST_PRE_ALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (go_pre && pre_all) |=> (open_q == '0));                 // R7
endmodule

// File: rtl/ddrct_burst.sv
module ddrct_burst
    import ddrct_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int CNT_W  = 4,
    parameter int MAX_CL = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_wr,
    input  logic             start_ap,
    input  logic [BA_W-1:0]  start_bank,
    input  logic [CNT_W-1:0] start_len,
    input  logic             kill,
    input  logic             cl_sel,
    output logic             busy,
    output logic             is_wr,
    output logic             ap,
    output logic [BA_W-1:0]  bank,
    output logic [CNT_W-1:0] beats,
    output logic             retire,
    output logic             rd_valid
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(2);

    burst_attr_t       attr;
    logic [MAX_CL-1:0] rd_pipe;

    assign busy   = (beats != '0);
    assign retire = (beats == STEP);
    assign is_wr  = attr.wr;
    assign ap     = attr.ap;

    always_ff @(posedge clk) begin
        if (rst) begin
            beats <= '0;
            attr  <= '0;
            bank  <= '0;
        end else if (kill) begin
            beats <= '0;
        end else if (start) begin
            beats   <= start_len;
            attr.wr <= start_wr;
            attr.ap <= start_ap;
            bank    <= start_bank;
        end else if (busy) begin
            beats <= beats - STEP;
        end
    end

    // Read window: the read-busy flag delayed by the latency
    always_ff @(posedge clk) begin
        if (rst) rd_pipe <= '0;
        else     rd_pipe <= {rd_pipe[MAX_CL-2:0], busy & ~attr.wr};
    end

    assign rd_valid = cl_sel ? rd_pipe[MAX_CL-1] : rd_pipe[MAX_CL-2];

    AST_BEATS_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (busy && !kill && !start) |=> (beats == $past(beats) - STEP));   // R3
    AST_KILL_ENDS_BURST: assert property (@(posedge clk) disable iff (rst)
        kill |=> !busy);                                                 // R8
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
    import ddrct_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = $clog2(NUM_BANKS),
    parameter int MAX_BL    = 8,
    parameter int CNT_W     = $clog2(MAX_BL) + 1,
    parameter int MAX_CL    = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 cke,
    input  logic                 a10,
    input  logic [BA_W-1:0]      ba,
    input  logic [1:0]           bl_sel,
    input  logic                 cl_sel,
    output logic                 act_stb,
    output logic                 rd_stb,
    output logic                 wr_stb,
    output logic                 pre_stb,
    output logic                 ref_stb,
    output logic                 cmd_err,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 burst_busy,
    output logic                 burst_wr,
    output logic [CNT_W-1:0]     burst_beats,
    output logic                 rd_valid
);
    op_e                  op;
    logic                 retire, b_ap, tail_ok, col_ok;
    logic [BA_W-1:0]      b_bank;
    logic [NUM_BANKS-1:0] ret_mask, eff_open;
    logic                 go_act, go_rd, go_wr, go_pre, go_ref, bad;
    logic [CNT_W-1:0]     len;

    ddrct_decode u_dec (
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .cke (cke), .op (op)
    );

    // Bank view after this edge's auto-close has been applied
    always_comb begin
        ret_mask = '0;
        if (retire && b_ap) ret_mask[b_bank] = 1'b1;
        eff_open = bank_open & ~ret_mask;
    end

    always_comb begin
        tail_ok = !burst_busy || retire;
        col_ok  = eff_open[ba] && tail_ok;
        go_act  = (op == OP_ACT) && !eff_open[ba];
        go_rd   = (op == OP_RD)  && col_ok;
        go_wr   = (op == OP_WR)  && col_ok;
        go_pre  = (op == OP_PRE);
        go_ref  = (op == OP_REF) && (eff_open == '0);
        bad     = ((op == OP_ACT) && !go_act) ||
                  ((op == OP_RD)  && !go_rd)  ||
                  ((op == OP_WR)  && !go_wr)  ||
                  ((op == OP_REF) && !go_ref);
        len     = CNT_W'(beats_of(bl_sel));
    end

    ddrct_banks #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_banks (
        .clk (clk), .rst (rst), .ret_mask (ret_mask),
        .go_act (go_act), .go_pre (go_pre), .pre_all (a10),
        .go_ref (go_ref), .idx (ba), .open_q (bank_open)
    );

    ddrct_burst #(.BA_W(BA_W), .CNT_W(CNT_W), .MAX_CL(MAX_CL)) u_burst (
        .clk (clk), .rst (rst),
        .start (go_rd || go_wr), .start_wr (go_wr), .start_ap (a10),
        .start_bank (ba), .start_len (len), .kill (go_pre),
        .cl_sel (cl_sel), .busy (burst_busy), .is_wr (burst_wr),
        .ap (b_ap), .bank (b_bank), .beats (burst_beats),
        .retire (retire), .rd_valid (rd_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_stb <= 1'b0;
            rd_stb  <= 1'b0;
            wr_stb  <= 1'b0;
            pre_stb <= 1'b0;
            ref_stb <= 1'b0;
            cmd_err <= 1'b0;
        end else begin
            act_stb <= go_act;
            rd_stb  <= go_rd;
            wr_stb  <= go_wr;
            pre_stb <= go_pre;
            ref_stb <= go_ref;
            cmd_err <= bad;
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({act_stb, rd_stb, wr_stb, pre_stb, ref_stb, cmd_err}));   // R1
    AST_BURST_BANK_OPEN: assert property (@(posedge clk) disable iff (rst)
        burst_busy |-> bank_open[b_bank]);                                 // R6
    AST_REF_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst)
        ref_stb |-> (bank_open == '0));                                    // R9
    AST_ERR_KEEPS_BANKS: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> (bank_open == ($past(bank_open) & ~$past(ret_mask)))); // R10
    AST_ERR_NO_NEW_BURST: assert property (@(posedge clk) disable iff (rst)
        (cmd_err && !$past(burst_busy)) |-> !burst_busy);                  // R10
endmodule

// File: tb/ddr_cmd_tracker_test.sv
module ddr_cmd_tracker_test;
    localparam int C_DES = 0, C_NOP = 1, C_ACT = 2, C_RD = 3, C_WR = 4,
                   C_PRE = 5, C_REF = 6, C_SREF = 7, C_MRS = 8, C_BST = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic       cke = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [1:0] bl_sel = 2'd0;
    logic       cl_sel = 1'b0;
    logic       act_stb, rd_stb, wr_stb, pre_stb, ref_stb, cmd_err;
    logic [3:0] bank_open;
    logic       burst_busy, burst_wr, rd_valid;
    logic [3:0] burst_beats;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 0;

    always #2.5 clk = ~clk;

    ddr_cmd_tracker uut (
        .clk (clk), .rst (rst), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .cke (cke), .a10 (a10), .ba (ba), .bl_sel (bl_sel),
        .cl_sel (cl_sel), .act_stb (act_stb), .rd_stb (rd_stb),
        .wr_stb (wr_stb), .pre_stb (pre_stb), .ref_stb (ref_stb),
        .cmd_err (cmd_err), .bank_open (bank_open), .burst_busy (burst_busy),
        .burst_wr (burst_wr), .burst_beats (burst_beats), .rd_valid (rd_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int strobes();
        return int'({act_stb, rd_stb, wr_stb, pre_stb, ref_stb, cmd_err});
    endfunction

    // Drive one command, wait for the edge that takes it, return at negedge
    task automatic cmd(input int c, input int b, input logic ap);
        cs_n = 1'b0; cke = 1'b1; a10 = ap; ba = 2'(b);
        case (c)
            C_DES:  begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b011; end
            C_ACT:  {ras_n, cas_n, we_n} = 3'b011;
            C_RD:   {ras_n, cas_n, we_n} = 3'b101;
            C_WR:   {ras_n, cas_n, we_n} = 3'b100;
            C_PRE:  {ras_n, cas_n, we_n} = 3'b010;
            C_REF:  {ras_n, cas_n, we_n} = 3'b001;
            C_SREF: begin {ras_n, cas_n, we_n} = 3'b001; cke = 1'b0; end
            C_MRS:  {ras_n, cas_n, we_n} = 3'b000;
            C_BST:  {ras_n, cas_n, we_n} = 3'b110;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R13: reset state
        chk("R13 strobes after reset", strobes(), 0);
        chk("R13 banks after reset", int'(bank_open), 0);
        chk("R13 burst after reset", int'(burst_beats), 0);
        chk("R13 rd_valid after reset", int'(rd_valid), 0);

        // Sweep: latency x length x read/write x auto-close x bank
        for (int cl = 0; cl < 2; cl++)
        for (int blc = 0; blc < 3; blc++)
        for (int rw = 0; rw < 2; rw++)
        for (int ap = 0; ap < 2; ap++)
        for (int b = 0; b < 4; b++) begin
            int len, lat, n, kmax;
            len = 2 << blc; lat = cl + 2; n = len / 2; kmax = lat + n + 1;
            bl_sel = 2'(blc); cl_sel = 1'(cl);
            cmd(C_ACT, b, 1'b0);
            chk("R2 act strobe", int'(act_stb), 1);
            chk("R2 bank set", int'(bank_open), 1 << b);
            cmd(rw ? C_WR : C_RD, b, 1'(ap));
            chk("R3 column strobe", int'(rw ? wr_stb : rd_stb), 1);
            chk("R3 burst_wr", int'(burst_wr), rw);
            for (int k = 0; k <= kmax; k++) begin
                chk("R4 beats left", int'(burst_beats), (k < n) ? len - 2 * k : 0);
                chk("R3 busy", int'(burst_busy), (k < n) ? 1 : 0);
                chk("R5 rd_valid", int'(rd_valid),
                    (rw == 0 && k >= lat && k < lat + n) ? 1 : 0);
                chk("R6 bank after auto-close", int'(bank_open),
                    (ap == 1 && k >= n) ? 0 : (1 << b));
                if (k < kmax) cmd(C_NOP, 0, 1'b0);
            end
            if (ap == 0) begin
                cmd(C_PRE, b, 1'b0);
                chk("R7 single close", int'(bank_open), 0);
            end
        end

        // R4: code 3 also gives 8 beats
        bl_sel = 2'd3; cl_sel = 1'b0;
        cmd(C_ACT, 0, 1'b0);
        cmd(C_RD, 0, 1'b0);
        chk("R4 code3 beats", int'(burst_beats), 8);
        cmd(C_PRE, 0, 1'b1);

        // R11: column command mid-burst vs on the last clock
        bl_sel = 2'd2;
        cmd(C_ACT, 0, 1'b0);
        cmd(C_RD, 0, 1'b0);
        cmd(C_RD, 0, 1'b0);
        chk("R11 early column is error", int'(cmd_err), 1);
        chk("R11 early column no strobe", int'(rd_stb), 0);
        chk("R11 count continues", int'(burst_beats), 6);
        cmd(C_NOP, 0, 1'b0);
        cmd(C_NOP, 0, 1'b0);
        chk("R11 last clock", int'(burst_beats), 2);
        cmd(C_WR, 0, 1'b0);
        chk("R11 gapless accepted", int'(wr_stb), 1);
        chk("R11 gapless restart", int'(burst_beats), 8);
        chk("R11 gapless write", int'(burst_wr), 1);
        // R8: close ends burst
        cmd(C_PRE, 0, 1'b0);
        chk("R8 close strobe", int'(pre_stb), 1);
        chk("R8 burst cut", int'(burst_beats), 0);
        chk("R8 busy cut", int'(burst_busy), 0);

        // R6: auto-close and a command at the same edge
        bl_sel = 2'd0;
        cmd(C_ACT, 1, 1'b0);
        cmd(C_RD, 1, 1'b1);
        chk("R6 short burst", int'(burst_beats), 2);
        cmd(C_ACT, 1, 1'b0);
        chk("R6 same-edge open accepted", int'(act_stb), 1);
        chk("R6 same-edge no error", int'(cmd_err), 0);
        chk("R6 bank reopened", int'(bank_open), 2);
        cmd(C_PRE, 0, 1'b1);

        // R8 close of another bank, R7 single vs all
        bl_sel = 2'd2;
        cmd(C_ACT, 2, 1'b0);
        cmd(C_ACT, 3, 1'b0);
        cmd(C_WR, 2, 1'b0);
        cmd(C_PRE, 0, 1'b0);
        chk("R8 close other bank cuts burst", int'(burst_busy), 0);
        chk("R7 closed bank untouched", int'(bank_open), 4'b1100);
        cmd(C_PRE, 3, 1'b0);
        chk("R7 single close", int'(bank_open), 4'b0100);
        cmd(C_PRE, 0, 1'b1);
        chk("R7 close all", int'(bank_open), 0);

        // R10: illegal commands
        cmd(C_ACT, 0, 1'b0);
        cmd(C_ACT, 0, 1'b0);
        chk("R10 open on open bank err", int'(cmd_err), 1);
        chk("R10 open on open no strobe", int'(act_stb), 0);
        chk("R10 banks kept", int'(bank_open), 1);
        cmd(C_RD, 2, 1'b0);
        chk("R10 read closed bank err", int'(cmd_err), 1);
        chk("R10 no burst", int'(burst_busy), 0);
        cmd(C_WR, 3, 1'b1);
        chk("R10 write closed bank err", int'(cmd_err), 1);
        chk("R10 write banks kept", int'(bank_open), 1);
        cmd(C_REF, 0, 1'b0);
        chk("R10 refresh with open bank err", int'(cmd_err), 1);
        chk("R10 refresh no strobe", int'(ref_stb), 0);
        chk("R10 refresh banks kept", int'(bank_open), 1);
        cmd(C_PRE, 0, 1'b0);

        // R9: legal refresh
        cmd(C_REF, 0, 1'b0);
        chk("R9 refresh strobe", int'(ref_stb), 1);
        chk("R9 refresh no error", int'(cmd_err), 0);
        chk("R9 banks closed", int'(bank_open), 0);

        // R12 / R1: ignored patterns
        cmd(C_ACT, 1, 1'b0);
        cmd(C_NOP, 0, 1'b0);
        chk("R1 strobe one cycle", strobes(), 0);
        chk("R12 nop banks", int'(bank_open), 2);
        cmd(C_MRS, 0, 1'b0);
        chk("R12 all-low ignored", strobes(), 0);
        cmd(C_SREF, 0, 1'b0);
        chk("R12 refresh cke low ignored", strobes(), 0);
        cmd(C_BST, 1, 1'b0);
        chk("R12 burst stop ignored", strobes(), 0);
        chk("R12 banks unchanged", int'(bank_open), 2);
        cmd(C_DES, 2, 1'b0);
        chk("R1 deselect no strobe", strobes(), 0);
        chk("R1 deselect banks", int'(bank_open), 2);
        cmd(C_PRE, 0, 1'b1);

        // R13: reset mid-burst
        cmd(C_ACT, 0, 1'b0);
        cmd(C_RD, 0, 1'b0);
        cmd(C_NOP, 0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        chk("R13 mid-burst banks", int'(bank_open), 0);
        chk("R13 mid-burst beats", int'(burst_beats), 0);
        chk("R13 mid-burst rd_valid", int'(rd_valid), 0);
        rst = 1'b0;
        cmd(C_NOP, 0, 1'b0);
        chk("R13 stays clear", int'(rd_valid), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule